// File: doc/BRIEF.md
# Wide Register Access Collector Bridge

This block sits between a 32-bit host register bus and a set of internal storage that is wider than the bus. Control registers are 128 bits wide and SRAM words are 64 bits wide. A wide value cannot be moved in one bus access, so the bridge makes multi-dword accesses coherent. On reads it takes a snapshot of the whole wide value and returns it one dword at a time. On writes it gathers dwords in a collector and raises one commit strobe only when the whole word is present.

Two write-only descriptor pointer registers, repeated in every page, follow different rules so that software can update them without taking a lock. A write to their top dword always commits. Low dwords that were not collected are written as zero. A stray low-dword write that would disturb another register's collection is dropped. Two plain 32-bit paged registers, an event-queue pointer and a timer command, pass straight through as single-dword writes. A timer command written in page 0 empties the collector.

The register and SRAM contents are outside the block. The bridge presents a read strobe with a target index, samples the live wide value in that same cycle, and presents a write strobe that carries the full wide value and the target index.

Top module: `wide_reg_bridge`

## Requirements
- R1: An ordinary control register is written as four dwords at byte offsets 0, 4, 8 and 12 of its 16-byte slot (address bits [3:2] give the dword, and dword 0 is bits [31:0]). The dwords may arrive in any order. `wr_stb` rises in the cycle after the last missing dword is written, with `wr_sram`=0, `wr_idx` = {0, host_addr[14:4]} and the assembled 128-bit value. No strobe is raised before that.
- R2: A write to a different ordinary register throws away any partial collection and starts a new one, so the earlier register's dwords never commit.
- R3: Addresses with host_addr[15]=1 select SRAM. Each 64-bit word has two dwords selected by host_addr[2]. A commit raises `wr_sram`=1 with `wr_idx` = host_addr[14:3], the word in `wr_data[63:0]` and zeros above it.
- R4: A read of dword 0, a read of a register other than the latched one, or a read while the latch is empty raises `rd_stb` in the same cycle, with `rd_sram`/`rd_idx` naming the target. The whole `rd_data` value is captured at that point.
- R5: `host_rvalid` is high in the cycle after `host_rd`, and `host_rdata` then holds the requested dword. A read of a higher dword of the latched register raises no `rd_stb` and returns the latched value, even if the live value has changed since.
- R6: The descriptor registers sit at page offsets 0x830 and 0x A10. A write to their dword 3 (offset +0xC) always commits in the next cycle. The upper dword comes from the write. Each lower dword comes from the collector if the collector holds that register and that dword, and is zero otherwise.
- R7: A write to dword 0, 1 or 2 of a descriptor register is dropped while the collector holds dwords of a different register. The collector keeps its contents, so that register can still complete.
- R8: Pages repeat every 0x2000 bytes. host_addr[14:13] is the page, and the special offsets are recognised in every page. `wr_idx` keeps the page bits.
- R9: A dword write to page offset 0x400 (event-queue pointer) or 0x420 (timer command) raises `nw_stb` in the next cycle, with `nw_timer` (1 for 0x420), `nw_page` and `nw_data`. An event-queue write leaves the collector untouched.
- R10: A timer command write in page 0 empties the collector. In any other page it leaves the collector untouched.
- R11: Each commit produces a `wr_stb` pulse exactly one cycle long.
- R12: While reset is held and right after it, `wr_stb`, `nw_stb`, `rd_stb` and `host_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host dword write request |
| host_rd | input | 1 | Host dword read request |
| host_addr | input | ADDR_W (16) | Host byte address; bit 15 selects SRAM |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| rd_stb | output | 1 | Capture strobe toward wide storage (read side effects) |
| rd_sram | output | 1 | Capture target is SRAM |
| rd_idx | output | IDX_W (12) | Capture target index |
| rd_data | input | 128 | Live wide value of the target named by rd_idx |
| wr_stb | output | 1 | Wide commit strobe |
| wr_sram | output | 1 | Commit target is SRAM |
| wr_idx | output | IDX_W (12) | Commit target index |
| wr_data | output | 128 | Committed wide value |
| nw_stb | output | 1 | Narrow paged register write strobe |
| nw_timer | output | 1 | 1: timer command, 0: event-queue pointer |
| nw_page | output | PAGE_W (2) | Page of the narrow write |
| nw_data | output | 32 | Narrow write data |

## Verification
The assertions assume the host issues at most one write and one read per cycle. They also assume `rd_data` is valid in the cycle `rd_stb` is high, because that is the only cycle the value is sampled. The stimulus never raises `host_wr` and `host_rd` together. It holds each request for exactly one cycle and sets `rd_data` before the read is issued. Random register indices are nudged away from the descriptor and narrow offsets, so an ordinary-register sequence never lands on a special decode by accident.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int DW          = 32;
  localparam int WIDE_DWORDS = 4;
  localparam int SRAM_DWORDS = 2;
  localparam int WIDE_W      = DW * WIDE_DWORDS;
  localparam int PAGE_SHIFT  = 13;

  localparam logic [PAGE_SHIFT-1:0] OFS_DESC_A = 13'h830;
  localparam logic [PAGE_SHIFT-1:0] OFS_DESC_B = 13'hA10;
  localparam logic [PAGE_SHIFT-1:0] OFS_EVQ    = 13'h400;
  localparam logic [PAGE_SHIFT-1:0] OFS_TIMER  = 13'h420;

  typedef enum logic [1:0] {K_WIDE, K_SRAM, K_DESC, K_NARROW} kind_e;

  function automatic logic desc_hit(input logic [PAGE_SHIFT-1:0] ofs);
    logic [PAGE_SHIFT-1:0] slot;
    slot = ofs & ~PAGE_SHIFT'(15);
    return (slot == OFS_DESC_A) || (slot == OFS_DESC_B);
  endfunction

  function automatic logic narrow_hit(input logic [PAGE_SHIFT-1:0] ofs);
    logic [PAGE_SHIFT-1:0] word;
    word = ofs & ~PAGE_SHIFT'(3);
    return (word == OFS_EVQ) || (word == OFS_TIMER);
  endfunction

  function automatic logic [DW-1:0] get_dword(input logic [WIDE_W-1:0] d,
                                              input logic [1:0] p);
    return d[p*DW +: DW];
  endfunction

  function automatic logic [WIDE_W-1:0] put_dword(input logic [WIDE_W-1:0] d,
                                                  input logic [1:0] p,
                                                  input logic [DW-1:0] w);
    logic [WIDE_W-1:0] r;
    r = d;
    r[p*DW +: DW] = w;
    return r;
  endfunction

  // Lower three dwords kept only where the mask says they were collected.
  function automatic logic [WIDE_W-DW-1:0] zero_fill(input logic [WIDE_W-1:0] d,
                                                     input logic [WIDE_DWORDS-1:0] m);
    logic [WIDE_W-DW-1:0] r;
    for (int i = 0; i < WIDE_DWORDS-1; i++)
      r[i*DW +: DW] = m[i] ? d[i*DW +: DW] : '0;
    return r;
  endfunction

  function automatic logic all_present(input logic [WIDE_DWORDS-1:0] m,
                                       input logic sram);
    return sram ? (&m[SRAM_DWORDS-1:0]) : (&m);
  endfunction
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = ADDR_W - 4,
  parameter int PAGE_W = ADDR_W - 1 - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        pos,
  output logic [PAGE_W-1:0] page,
  output logic              timer_hit
);
  logic [PAGE_SHIFT-1:0] ofs;
  assign ofs  = addr[PAGE_SHIFT-1:0];
  assign page = addr[ADDR_W-2:PAGE_SHIFT];

  always_comb begin
    timer_hit = 1'b0;
    if (addr[ADDR_W-1]) begin
      kind = K_SRAM;
      idx  = addr[ADDR_W-2:3];
      pos  = {1'b0, addr[2]};
    end else begin
      idx = {1'b0, addr[ADDR_W-2:4]};
      pos = addr[3:2];
      if (narrow_hit(ofs)) begin
        kind      = K_NARROW;
        timer_hit = ((ofs & ~PAGE_SHIFT'(3)) == OFS_TIMER);
      end else if (desc_hit(ofs)) begin
        kind = K_DESC;
      end else begin
        kind = K_WIDE;
      end
    end
  end
endmodule

// File: rtl/wrb_read_latch.sv
module wrb_read_latch
  import wrb_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              sram,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        pos,
  input  logic [WIDE_W-1:0] live,
  output logic              cap,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);
  logic              lt_valid;
  logic [IDX_W:0]    lt_tgt;
  logic [WIDE_W-1:0] lt_data;
  logic [IDX_W:0]    tgt;

  assign tgt = {sram, idx};
  assign cap = rd_en && ((pos == 2'd0) || !lt_valid || (lt_tgt != tgt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_valid <= 1'b0;
      lt_tgt   <= '0;
      lt_data  <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (cap) begin
        lt_valid <= 1'b1;
        lt_tgt   <= tgt;
        lt_data  <= sram ? {{(WIDE_W-SRAM_DWORDS*DW){1'b0}}, live[SRAM_DWORDS*DW-1:0]} : live;
      end
      if (rd_en) rdata <= get_dword(cap ? live : lt_data, pos);
    end
  end
endmodule

// File: rtl/wrb_collector.sv
module wrb_collector
  import wrb_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int PAGE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  kind_e                  kind,
  input  logic [IDX_W-1:0]       idx,
  input  logic [1:0]             pos,
  input  logic [PAGE_W-1:0]      page,
  input  logic                   timer_hit,
  input  logic [DW-1:0]          wdata,
  output logic                   wr_stb,
  output logic                   wr_sram,
  output logic [IDX_W-1:0]       wr_idx,
  output logic [WIDE_W-1:0]      wr_data,
  output logic                   nw_stb,
  output logic                   nw_timer,
  output logic [PAGE_W-1:0]      nw_page,
  output logic [DW-1:0]          nw_data,
  output logic                   ev_commit,
  output logic                   ev_drop,
  output logic                   ev_inval,
  output logic [WIDE_DWORDS-1:0] mask_q
);
  logic [IDX_W:0]          tgt_q, tgt_d, tgt;
  logic [WIDE_W-1:0]       data_q, data_d, out_d, merged_data;
  logic [WIDE_DWORDS-1:0]  mask_d, base_mask, merged_mask;
  logic                    is_sram, same, ev_narrow;

  assign is_sram     = (kind == K_SRAM);
  assign tgt         = {is_sram, idx};
  assign same        = (mask_q != '0) && (tgt_q == tgt);
  assign base_mask   = same ? mask_q : '0;
  assign merged_mask = base_mask | (WIDE_DWORDS'(1) << pos);
  assign merged_data = put_dword(same ? data_q : '0, pos, wdata);

  always_comb begin
    mask_d    = mask_q;
    tgt_d     = tgt_q;
    data_d    = data_q;
    out_d     = '0;
    ev_commit = 1'b0;
    ev_drop   = 1'b0;
    ev_inval  = 1'b0;
    ev_narrow = 1'b0;
    if (wr_en) begin
      unique case (kind)
        K_WIDE, K_SRAM: begin
          if (all_present(merged_mask, is_sram)) begin
            ev_commit = 1'b1;
            out_d     = merged_data;
            mask_d    = '0;
          end else begin
            mask_d = merged_mask;
            tgt_d  = tgt;
            data_d = merged_data;
          end
        end
        K_DESC: begin
          if (pos == 2'd3) begin
            ev_commit = 1'b1;
            out_d     = {wdata, zero_fill(data_q, base_mask)};
            if (same) mask_d = '0;
          end else if ((mask_q != '0) && !same) begin
            ev_drop = 1'b1;
          end else begin
            mask_d = merged_mask;
            tgt_d  = tgt;
            data_d = merged_data;
          end
        end
        K_NARROW: begin
          ev_narrow = 1'b1;
          if (timer_hit && (page == '0)) begin
            ev_inval = 1'b1;
            mask_d   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      tgt_q    <= '0;
      data_q   <= '0;
      wr_stb   <= 1'b0;
      wr_sram  <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      nw_stb   <= 1'b0;
      nw_timer <= 1'b0;
      nw_page  <= '0;
      nw_data  <= '0;
    end else begin
      mask_q <= mask_d;
      tgt_q  <= tgt_d;
      data_q <= data_d;
      wr_stb <= ev_commit;
      nw_stb <= ev_narrow;
      if (ev_commit) begin
        wr_sram <= is_sram;
        wr_idx  <= idx;
        wr_data <= out_d;
      end
      if (ev_narrow) begin
        nw_timer <= timer_hit;
        nw_page  <= page;
        nw_data  <= wdata;
      end
    end
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = ADDR_W - 4,
  parameter int PAGE_W = ADDR_W - 1 - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rvalid,
  output logic              rd_stb,
  output logic              rd_sram,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WIDE_W-1:0] rd_data,
  output logic              wr_stb,
  output logic              wr_sram,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WIDE_W-1:0] wr_data,
  output logic              nw_stb,
  output logic              nw_timer,
  output logic [PAGE_W-1:0] nw_page,
  output logic [DW-1:0]     nw_data
);
  kind_e                  dec_kind;
  logic [IDX_W-1:0]       dec_idx;
  logic [1:0]             dec_pos;
  logic [PAGE_W-1:0]      dec_page;
  logic                   dec_timer;
  logic                   ev_commit, ev_drop, ev_inval;
  logic [WIDE_DWORDS-1:0] coll_mask;

  wrb_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_dec (
    .addr(host_addr), .kind(dec_kind), .idx(dec_idx), .pos(dec_pos),
    .page(dec_page), .timer_hit(dec_timer)
  );

  assign rd_sram = (dec_kind == K_SRAM);
  assign rd_idx  = dec_idx;

  wrb_read_latch #(.IDX_W(IDX_W)) u_rl (
    .clk(clk), .rst_n(rst_n), .rd_en(host_rd), .sram(rd_sram), .idx(dec_idx),
    .pos(dec_pos), .live(rd_data), .cap(rd_stb), .rdata(host_rdata),
    .rvalid(host_rvalid)
  );

  wrb_collector #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_col (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .kind(dec_kind), .idx(dec_idx),
    .pos(dec_pos), .page(dec_page), .timer_hit(dec_timer), .wdata(host_wdata),
    .wr_stb(wr_stb), .wr_sram(wr_sram), .wr_idx(wr_idx), .wr_data(wr_data),
    .nw_stb(nw_stb), .nw_timer(nw_timer), .nw_page(nw_page), .nw_data(nw_data),
    .ev_commit(ev_commit), .ev_drop(ev_drop), .ev_inval(ev_inval),
    .mask_q(coll_mask)
  );
endmodule

// File: rtl/wrb_chk.sv
module wrb_chk
  import wrb_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_wr,
  input logic                   host_rd,
  input logic [DW-1:0]          host_wdata,
  input logic                   host_rvalid,
  input logic                   rd_stb,
  input logic                   wr_stb,
  input logic [WIDE_W-1:0]      wr_data,
  input logic                   nw_stb,
  input logic                   ev_drop,
  input logic                   ev_inval,
  input kind_e                  dec_kind,
  input logic [1:0]             dec_pos,
  input logic [WIDE_DWORDS-1:0] coll_mask
);
  AST_WR_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(host_wr)); // R1
  AST_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> host_rd); // R4
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid); // R5
  AST_DESC_TOP_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && dec_kind == K_DESC && dec_pos == 2'd3) |=>
      (wr_stb && wr_data[WIDE_W-1 -: DW] == $past(host_wdata))); // R6
  AST_DROP_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (coll_mask == $past(coll_mask))); // R7
  AST_NARROW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && dec_kind == K_NARROW) |=> (nw_stb && !wr_stb)); // R9
  AST_TIMER_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inval |=> (coll_mask == '0)); // R10
endmodule

bind wide_reg_bridge wrb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_wdata(host_wdata), .host_rvalid(host_rvalid), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .wr_data(wr_data), .nw_stb(nw_stb), .ev_drop(ev_drop),
  .ev_inval(ev_inval), .dec_kind(dec_kind), .dec_pos(dec_pos),
  .coll_mask(coll_mask)
);

// File: tb/tb_wide_reg_bridge.sv
module tb_wide_reg_bridge;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0]  host_addr = '0;
  logic [31:0]  host_wdata = '0;
  logic [31:0]  host_rdata;
  logic         host_rvalid, rd_stb, rd_sram;
  logic [11:0]  rd_idx, wr_idx;
  logic [127:0] rd_data = '0, wr_data;
  logic         wr_stb, wr_sram, nw_stb, nw_timer;
  logic [1:0]   nw_page;
  logic [31:0]  nw_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wide_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .rd_stb(rd_stb), .rd_sram(rd_sram),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_stb(wr_stb), .wr_sram(wr_sram),
    .wr_idx(wr_idx), .wr_data(wr_data), .nw_stb(nw_stb), .nw_timer(nw_timer),
    .nw_page(nw_page), .nw_data(nw_data)
  );

  function automatic logic [11:0] csr_idx(input logic [15:0] a);
    return {1'b0, a[14:4]};
  endfunction

  function automatic logic [127:0] pack4(input logic [31:0] d3, d2, d1, d0);
    return {d3, d2, d1, d0};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic stb,
                    output logic [11:0] ix, output logic [31:0] q);
    host_rd = 1'b1; host_addr = a;
    #1 stb = rd_stb; ix = rd_idx;
    @(negedge clk);
    host_rd = 1'b0;
    q = host_rdata;
    chk(host_rvalid, "R5 rvalid", 128'(host_rvalid), 128'd1);
  endtask

  task automatic no_commit(input string tag);
    chk(!wr_stb, tag, 128'(wr_stb), 128'd0);
  endtask

  task automatic commit(input string tag, input logic sram,
                        input logic [11:0] ix, input logic [127:0] d);
    chk(wr_stb && wr_sram == sram && wr_idx == ix && wr_data == d, tag,
        wr_data, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic        s;
    logic [11:0] ix;
    logic [31:0] q;
    logic [127:0] x, y;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    chk(!wr_stb && !nw_stb && !host_rvalid && !rd_stb, "R12 in reset",
        {wr_stb, nw_stb, host_rvalid, rd_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_stb && !nw_stb && !host_rvalid && !rd_stb, "R12 after reset",
        {wr_stb, nw_stb, host_rvalid, rd_stb}, 0);

    // R1 partial then complete, in order
    wr(16'h0100, 32'hA0); no_commit("R1 partial d0");
    wr(16'h0104, 32'hA1); no_commit("R1 partial d1");
    wr(16'h0108, 32'hA2); no_commit("R1 partial d2");
    wr(16'h010C, 32'hA3);
    commit("R1 full", 1'b0, 12'h010, pack4(32'hA3, 32'hA2, 32'hA1, 32'hA0));
    @(negedge clk);
    no_commit("R11 single pulse");

    // R1 out of order
    wr(16'h020C, 32'hB3); wr(16'h0204, 32'hB1); wr(16'h0200, 32'hB0);
    no_commit("R1 ooo partial");
    wr(16'h0208, 32'hB2);
    commit("R1 ooo", 1'b0, 12'h020, pack4(32'hB3, 32'hB2, 32'hB1, 32'hB0));

    // R2 interleaved registers
    wr(16'h0300, 32'hC0); wr(16'h0304, 32'hC1);
    wr(16'h0310, 32'hD0); wr(16'h0314, 32'hD1); wr(16'h0318, 32'hD2);
    wr(16'h031C, 32'hD3);
    commit("R2 second reg", 1'b0, 12'h031, pack4(32'hD3, 32'hD2, 32'hD1, 32'hD0));
    wr(16'h0308, 32'hC2); wr(16'h030C, 32'hC3);
    no_commit("R2 first reg lost");

    // R3 SRAM
    wr(16'h812C, 32'hE1); no_commit("R3 sram partial");
    wr(16'h8128, 32'hE0);
    commit("R3 sram", 1'b1, 12'h025, pack4(0, 0, 32'hE1, 32'hE0));

    // R6/R8 descriptor zero fill in page 1
    wr(16'h283C, 32'hF3);
    commit("R6 R8 desc zero fill", 1'b0, 12'h283, pack4(32'hF3, 0, 0, 0));

    // R6 descriptor with collected low dwords
    wr(16'h0A10, 32'h10); wr(16'h0A14, 32'h11); no_commit("R6 desc low");
    wr(16'h0A1C, 32'h13);
    commit("R6 desc merge", 1'b0, 12'h0A1, pack4(32'h13, 0, 32'h11, 32'h10));

    // R7 drop of stray descriptor write
    wr(16'h4100, 32'h20); wr(16'h4104, 32'h21);
    wr(16'h4834, 32'hDEAD); no_commit("R7 stray dropped");
    wr(16'h483C, 32'h2F);
    commit("R7 desc no stray data", 1'b0, 12'h483, pack4(32'h2F, 0, 0, 0));
    wr(16'h4108, 32'h22); wr(16'h410C, 32'h23);
    commit("R7 collector intact", 1'b0, 12'h410, pack4(32'h23, 32'h22, 32'h21, 32'h20));

    // R9 narrow event-queue write
    wr(16'h0500, 32'h30); wr(16'h0504, 32'h31);
    wr(16'h6400, 32'h55);
    chk(nw_stb && !nw_timer && nw_page == 2'd3 && nw_data == 32'h55 && !wr_stb,
        "R9 evq strobe", {nw_stb, nw_timer, nw_page, nw_data}, {1'b1, 1'b0, 2'd3, 32'h55});
    wr(16'h0508, 32'h32); wr(16'h050C, 32'h33);
    commit("R9 collector untouched", 1'b0, 12'h050, pack4(32'h33, 32'h32, 32'h31, 32'h30));

    // R10 timer in page 1 keeps, page 0 empties
    wr(16'h0600, 32'h40); wr(16'h0604, 32'h41);
    wr(16'h2420, 32'h66);
    chk(nw_stb && nw_timer && nw_page == 2'd1, "R10 timer strobe",
        {nw_stb, nw_timer, nw_page}, {1'b1, 1'b1, 2'd1});
    wr(16'h0608, 32'h42); wr(16'h060C, 32'h43);
    commit("R10 page1 keeps", 1'b0, 12'h060, pack4(32'h43, 32'h42, 32'h41, 32'h40));
    wr(16'h0700, 32'h50); wr(16'h0704, 32'h51);
    wr(16'h0420, 32'h77);
    wr(16'h0708, 32'h52); wr(16'h070C, 32'h53);
    no_commit("R10 page0 empties");

    // R4/R5 read latch
    x = {32'h1111_0003, 32'h1111_0002, 32'h1111_0001, 32'h1111_0000};
    rd_data = x;
    rd(16'h0300, s, ix, q);
    chk(s && ix == 12'h030 && q == x[31:0], "R4 capture d0", {s, ix, q}, {1'b1, 12'h030, x[31:0]});
    y = {32'h2222_0003, 32'h2222_0002, 32'h2222_0001, 32'h2222_0000};
    rd_data = y;
    rd(16'h0308, s, ix, q);
    chk(!s && q == x[95:64], "R5 stale latch", {s, q}, {1'b0, x[95:64]});
    rd(16'h050C, s, ix, q);
    chk(s && ix == 12'h050 && q == y[127:96], "R4 other reg", {s, ix, q}, {1'b1, 12'h050, y[127:96]});
    rd(16'h812C, s, ix, q);
    chk(s && rd_sram == 1'b1 && q == y[63:32], "R4 sram capture", {s, q}, {1'b1, y[63:32]});

    // Random full-register writes in shuffled order
    for (int it = 0; it < 40; it++) begin
      logic [10:0] ri;
      logic [15:0] base;
      logic [31:0] d [4];
      int ord [4];
      ri = 11'($urandom);
      if (ri[8:0] == 9'h040 || ri[8:0] == 9'h042 || ri[8:0] == 9'h083 || ri[8:0] == 9'h0A1)
        ri[0] = ~ri[0];
      base = {1'b0, ri, 4'h0};
      for (int k = 0; k < 4; k++) begin d[k] = $urandom; ord[k] = k; end
      for (int k = 3; k > 0; k--) begin
        int j; int t;
        j = int'($urandom % (k + 1)); t = ord[k]; ord[k] = ord[j]; ord[j] = t;
      end
      for (int k = 0; k < 4; k++) begin
        wr(base | 16'(ord[k] * 4), d[ord[k]]);
        if (k < 3) no_commit("R1 random partial");
      end
      commit("R1 random", 1'b0, csr_idx(base), pack4(d[3], d[2], d[1], d[0]));
    end

    // Random latch reads
    for (int it = 0; it < 20; it++) begin
      logic [15:0] base;
      int k;
      base = {1'b0, 11'($urandom), 4'h0};
      x = {$urandom, $urandom, $urandom, $urandom};
      rd_data = x;
      rd(base, s, ix, q);
      chk(s && q == x[31:0], "R4 random capture", {s, q}, {1'b1, x[31:0]});
      rd_data = {$urandom, $urandom, $urandom, $urandom};
      k = 1 + int'($urandom % 3);
      rd(base | 16'(k * 4), s, ix, q);
      chk(!s && q == x[k*32 +: 32], "R5 random stale", {s, q}, {1'b0, x[k*32 +: 32]});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule